// File: doc/BRIEF.md
# Single-Wait-State Controller for a Tightly-Coupled Instruction Memory

This block sits between a processor core's tightly-coupled memory port and a synchronous memory that cannot answer within one cycle. Every access it accepts is stretched by exactly one wait state. The core raises chip-select together with an address, and the block accepts the request. It then drives a pipelined wait signal back to the core and, for reads, returns the addressed word with a one-cycle valid strobe.

The wait signal is generated one cycle ahead by a two-state machine. It rests asserted while idle. The core only looks at it while an access is in flight, so this idle level stalls nothing. It drops for one cycle after a request has been accepted, which announces that the access finishes on the next cycle. The cycle in which an access finishes can carry a fresh request, so a stream of back-to-back accesses runs at one access every two cycles. Address, direction and write data are captured when the request is accepted. The core is free to change them afterwards. Single-word writes use the same timing as reads but produce no valid strobe.

Top module: `tcm_wait_gen`

## Requirements
- R1: A clock edge with `rst` high leaves `tcm_wait` = 1, `tcm_rvalid` = 0 and `tcm_rdata` = 0 in the next cycle, and drops any access in flight.
- R2: While no access is in flight `tcm_wait` is 1, including the cycle in which `tcm_cs` is raised.
- R3: In the cycle after an accepted request `tcm_wait` is 0. In the cycle after that it is 1 again, whatever the inputs are.
- R4: A read (`tcm_cs` = 1, `tcm_we` = 0) accepted in cycle T gives `tcm_rvalid` = 1 for exactly cycle T+2, with `tcm_rdata` equal to the word at the accepted address.
- R5: A write (`tcm_cs` = 1, `tcm_we` = 1) accepted in cycle T stores `tcm_wdata` at the accepted address by the end of cycle T+1 and never raises `tcm_rvalid`.
- R6: A request raised in the cycle an access finishes (`tcm_wait` = 1 again) is accepted, so each back-to-back access still takes exactly one wait state.
- R7: `tcm_cs` raised in a cycle where `tcm_wait` = 0 is ignored. It starts no access and produces no `tcm_rvalid`.
- R8: Address, direction and write data are taken only in the accepted request cycle. Changing `tcm_addr` later does not change the word returned.
- R9: Before any write, word i of the memory holds the low DW bits of (i × 0x00010001) XOR `INIT_KEY`, with `INIT_KEY` defaulting to 0xC3C30000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tcm_cs | input | 1 | Access request from the core |
| tcm_we | input | 1 | 1 = write, 0 = read, taken with the request |
| tcm_addr | input | AW | Word address, taken with the request |
| tcm_wdata | input | DW | Write data, taken with the request |
| tcm_wait | output | 1 | Pipelined wait: 0 means the access in flight finishes next cycle |
| tcm_rdata | output | DW | Read data, valid when `tcm_rvalid` is 1, held otherwise |
| tcm_rvalid | output | 1 | One-cycle strobe marking returned read data |

## Verification
If the state machine were stuck in the idle state, `tcm_wait` would never drop. The first read would then lack its valid strobe two cycles later. If it were stuck pending, `tcm_wait` would stay low across two cycles. Either fault shows at the ports within two cycles of the first request. A wrongly captured address or a lost write shows as a data mismatch on the very next read of that word. The bench compares that read against a reference array. Accepting a request during the wait-low cycle would surface as an extra valid strobe two cycles later.

// File: rtl/tcmw_pkg.sv
package tcmw_pkg;
  // State of the single-wait-state sequencer
  typedef enum logic {
    ST_IDLE = 1'b0,  // idle or request cycle, wait driven high
    ST_PEND = 1'b1   // access finishing next cycle, wait driven low
  } tcmw_state_t;
endpackage

// File: rtl/tcmw_fsm.sv
module tcmw_fsm
  import tcmw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  output tcmw_state_t state,
  output logic        accept,
  output logic        wait_o
);
  tcmw_state_t state_q;
  logic        wait_q;

  // A request counts only while idle; in the pending cycle it is ignored.
  assign accept = req && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wait_q  <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= accept ? ST_PEND : ST_IDLE;
          wait_q  <= !accept;
        end
        ST_PEND: begin
          state_q <= ST_IDLE;   // unconditional return
          wait_q  <= 1'b1;
        end
        default: begin
          state_q <= ST_IDLE;
          wait_q  <= 1'b1;
        end
      endcase
    end
  end

  assign state  = state_q;
  assign wait_o = wait_q;
endmodule

// File: rtl/tcmw_req_latch.sv
module tcmw_req_latch #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          load,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  localparam int CW = 1 + AW + DW;

  logic [CW-1:0] hold_q;

  // Data path register: no reset needed, load is already gated by reset.
  always_ff @(posedge clk) begin
    if (load) hold_q <= {we_i, addr_i, wdata_i};
  end

  assign we_o    = hold_q[CW-1];
  assign addr_o  = hold_q[CW-2 -: AW];
  assign wdata_o = hold_q[DW-1:0];
endmodule

// File: rtl/tcmw_mem.sv
module tcmw_mem #(
  parameter int            AW       = 6,
  parameter int            DW       = 32,
  parameter logic [DW-1:0] INIT_KEY = DW'(32'hC3C3_0000)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];
  logic [DW-1:0] rdata_q;

  // Power-up content, expressible as a RAM initial image
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      store_q[i] = DW'(32'(i) * 32'h0001_0001) ^ INIT_KEY;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) store_q[addr] <= wdata;
  end

  // Registered read port with synchronous reset on the output register
  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= store_q[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/tcm_wait_gen.sv
module tcm_wait_gen
  import tcmw_pkg::*;
#(
  parameter int            AW       = 6,
  parameter int            DW       = 32,
  parameter logic [DW-1:0] INIT_KEY = DW'(32'hC3C3_0000)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tcm_cs,
  input  logic          tcm_we,
  input  logic [AW-1:0] tcm_addr,
  input  logic [DW-1:0] tcm_wdata,
  output logic          tcm_wait,
  output logic [DW-1:0] tcm_rdata,
  output logic          tcm_rvalid
);
  tcmw_state_t   state;
  logic          accept;
  logic          cap_we;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_wdata;
  logic          pend;
  logic          rvalid_q;

  tcmw_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .req    (tcm_cs),
    .state  (state),
    .accept (accept),
    .wait_o (tcm_wait)
  );

  tcmw_req_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk     (clk),
    .load    (accept && !rst),
    .we_i    (tcm_we),
    .addr_i  (tcm_addr),
    .wdata_i (tcm_wdata),
    .we_o    (cap_we),
    .addr_o  (cap_addr),
    .wdata_o (cap_wdata)
  );

  assign pend = (state == ST_PEND) && !rst;

  tcmw_mem #(.AW(AW), .DW(DW), .INIT_KEY(INIT_KEY)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .rd_en (pend && !cap_we),
    .wr_en (pend && cap_we),
    .addr  (cap_addr),
    .wdata (cap_wdata),
    .rdata (tcm_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) rvalid_q <= 1'b0;
    else     rvalid_q <= pend && !cap_we;
  end

  assign tcm_rvalid = rvalid_q;
endmodule

// File: rtl/tcmw_chk.sv
module tcmw_chk #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          tcm_cs,
  input logic          tcm_we,
  input logic [AW-1:0] tcm_addr,
  input logic [DW-1:0] tcm_wdata,
  input logic          tcm_wait,
  input logic [DW-1:0] tcm_rdata,
  input logic          tcm_rvalid
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (tcm_wait && !tcm_rvalid && tcm_rdata == '0));

  // R2
  req_wait_low_next_chk: assert property (@(posedge clk) disable iff (rst)
    (tcm_cs && tcm_wait) |=> !tcm_wait);

  // R3
  single_wait_low_chk: assert property (@(posedge clk) disable iff (rst)
    !tcm_wait |=> tcm_wait);

  // R4
  read_valid_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (tcm_cs && tcm_wait && !tcm_we) |=> ##1 tcm_rvalid);

  // R4
  valid_after_wait_low_chk: assert property (@(posedge clk) disable iff (rst)
    tcm_rvalid |-> $past(!tcm_wait));

  // R5
  write_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (tcm_cs && tcm_wait && tcm_we) |=> ##1 !tcm_rvalid);

  // R4
  valid_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    tcm_rvalid |=> !tcm_rvalid);
endmodule

bind tcm_wait_gen tcmw_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tcm_cs     (tcm_cs),
  .tcm_we     (tcm_we),
  .tcm_addr   (tcm_addr),
  .tcm_wdata  (tcm_wdata),
  .tcm_wait   (tcm_wait),
  .tcm_rdata  (tcm_rdata),
  .tcm_rvalid (tcm_rvalid)
);

// File: tb/sim_tcm_wait_gen.sv
module sim_tcm_wait_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;
  localparam int NROWS = 20;

  typedef struct packed {
    logic          cs;
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          ew;    // expected wait in this cycle
    logic          ev;    // expected rvalid in this cycle
    logic [AW-1:0] eaddr; // address whose word rdata must hold when ev
  } row_t;

  // One row per cycle: inputs driven in that cycle, outputs seen in it.
  localparam row_t TBL [NROWS] = '{
    '{1'b0, 1'b0, 6'd0,  32'h0,          1'b1, 1'b0, 6'd0 },  // 0 idle
    '{1'b1, 1'b0, 6'd5,  32'h0,          1'b1, 1'b0, 6'd0 },  // 1 read 5
    '{1'b0, 1'b0, 6'd0,  32'h0,          1'b0, 1'b0, 6'd0 },  // 2
    '{1'b0, 1'b0, 6'd0,  32'h0,          1'b1, 1'b1, 6'd5 },  // 3 data 5
    '{1'b1, 1'b0, 6'd10, 32'h0,          1'b1, 1'b0, 6'd0 },  // 4 read 10
    '{1'b0, 1'b0, 6'd0,  32'h0,          1'b0, 1'b0, 6'd0 },  // 5
    '{1'b1, 1'b0, 6'd11, 32'h0,          1'b1, 1'b1, 6'd10},  // 6 back-to-back
    '{1'b0, 1'b0, 6'd0,  32'h0,          1'b0, 1'b0, 6'd0 },  // 7
    '{1'b1, 1'b1, 6'd20, 32'hDEAD_0001,  1'b1, 1'b1, 6'd11},  // 8 write 20
    '{1'b0, 1'b0, 6'd0,  32'h0,          1'b0, 1'b0, 6'd0 },  // 9
    '{1'b1, 1'b0, 6'd20, 32'h0,          1'b1, 1'b0, 6'd0 },  // 10 read 20
    '{1'b1, 1'b0, 6'd30, 32'h0,          1'b0, 1'b0, 6'd0 },  // 11 cs ignored
    '{1'b0, 1'b0, 6'd0,  32'h0,          1'b1, 1'b1, 6'd20},  // 12 data 20
    '{1'b0, 1'b0, 6'd0,  32'h0,          1'b1, 1'b0, 6'd0 },  // 13 no extra
    '{1'b1, 1'b0, 6'd63, 32'h0,          1'b1, 1'b0, 6'd0 },  // 14 read 63
    '{1'b0, 1'b0, 6'd1,  32'h0,          1'b0, 1'b0, 6'd0 },  // 15 addr moves
    '{1'b1, 1'b0, 6'd0,  32'h0,          1'b1, 1'b1, 6'd63},  // 16 read 0
    '{1'b0, 1'b0, 6'd2,  32'h0,          1'b0, 1'b0, 6'd0 },  // 17
    '{1'b0, 1'b0, 6'd0,  32'h0,          1'b1, 1'b1, 6'd0 },  // 18 data 0
    '{1'b0, 1'b0, 6'd0,  32'h0,          1'b1, 1'b0, 6'd0 }   // 19
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          tcm_cs;
  logic          tcm_we;
  logic [AW-1:0] tcm_addr;
  logic [DW-1:0] tcm_wdata;
  logic          tcm_wait;
  logic [DW-1:0] tcm_rdata;
  logic          tcm_rvalid;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  tcm_wait_gen #(.AW(AW), .DW(DW)) u0 (
    .clk        (clk),
    .rst        (rst),
    .tcm_cs     (tcm_cs),
    .tcm_we     (tcm_we),
    .tcm_addr   (tcm_addr),
    .tcm_wdata  (tcm_wdata),
    .tcm_wait   (tcm_wait),
    .tcm_rdata  (tcm_rdata),
    .tcm_rvalid (tcm_rvalid)
  );

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic cs, input logic we,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    tcm_cs = cs; tcm_we = we; tcm_addr = a; tcm_wdata = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R9 reference power-up content
    for (int i = 0; i < DEPTH; i++)
      ref_mem[i] = (32'(i) * 32'h0001_0001) ^ 32'hC3C3_0000;

    rst = 1'b1;
    drive(1'b0, 1'b0, '0, '0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 wait", {31'b0, tcm_wait}, 32'd1);
    check("R1 rvalid", {31'b0, tcm_rvalid}, 32'd0);
    check("R1 rdata", tcm_rdata, 32'd0);
    rst = 1'b0;

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int r = 0; r < NROWS; r++) begin
      check($sformatf("R2/R3 wait row %0d", r), {31'b0, tcm_wait},
            {31'b0, TBL[r].ew});
      check($sformatf("R4/R5/R7 rvalid row %0d", r), {31'b0, tcm_rvalid},
            {31'b0, TBL[r].ev});
      if (TBL[r].ev)
        check($sformatf("R4/R8/R9 rdata row %0d", r), tcm_rdata,
              ref_mem[TBL[r].eaddr]);
      if (TBL[r].cs && TBL[r].we && TBL[r].ew)
        ref_mem[TBL[r].addr] = TBL[r].wdata;
      drive(TBL[r].cs, TBL[r].we, TBL[r].addr, TBL[r].wdata);
      @(negedge clk);
    end

    // R6 continuous back-to-back reads
    for (int k = 0; k < 16; k++) begin
      check("R6 wait on request", {31'b0, tcm_wait}, 32'd1);
      if (k > 0) begin
        check("R6 rvalid", {31'b0, tcm_rvalid}, 32'd1);
        check("R6 rdata", tcm_rdata, ref_mem[(k-1)*3+2]);
      end
      drive(1'b1, 1'b0, AW'(k*3+2), '0);
      @(negedge clk);
      check("R6 wait low", {31'b0, tcm_wait}, 32'd0);
      drive(1'b0, 1'b0, '0, '0);
      @(negedge clk);
    end
    check("R6 last rvalid", {31'b0, tcm_rvalid}, 32'd1);
    check("R6 last rdata", tcm_rdata, ref_mem[15*3+2]);
    @(negedge clk);

    // R1 reset while an access is in flight
    drive(1'b1, 1'b0, 6'd7, '0);
    @(negedge clk);
    drive(1'b0, 1'b0, '0, '0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid wait", {31'b0, tcm_wait}, 32'd1);
    check("R1 mid rvalid", {31'b0, tcm_rvalid}, 32'd0);
    check("R1 mid rdata", tcm_rdata, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 dropped access", {31'b0, tcm_rvalid}, 32'd0);
    check("R1 idle wait", {31'b0, tcm_wait}, 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule